// File: doc/BRIEF.md
# Core Stack Address Drive Decoder

This block turns a memory address and the cycle's timing strobes into one-hot select strobes for the drive lines of a coincident-current core stack. The X plane is driven as 16 groups of 8 lines and the Y plane as 8 groups of 8 lines. X reads and X writes drive two separate column-line sets but share the group lines. Each direction has its own pair of half-decoders for the group lines, and one address bit picks the lower or upper half.

The Y decoders are live only inside a read window. The window opens on a pre-read strobe and closes when the main read strobe drops. A three-bit stack-module code is captured from the top of the address on the rising edge of an address-valid strobe and decoded to one of five module selects. A read and a write asserted together are flagged as a conflict, and no X line is driven while the conflict lasts. The analog drive stages (pulse transformers, current switches, sense and inhibit circuits) sit outside this block and are driven by its outputs.

Address fields: bits 2:0 give the X column, bits 5:3 the X group within a half, bit 6 the X half (1 = upper), bits 9:7 the Y column, bits 12:10 the Y group, and bits 15:13 the stack-module code.

Top module: `core_addr_drive`

## Requirements
- R1: While `rd`=1 and `wr`=0, `x_rcol` has only bit `addr[2:0]` set. At every other time `x_rcol` is all zero.
- R2: While `wr`=1 and `rd`=0, `x_wcol` has only bit `addr[2:0]` set. At every other time `x_wcol` is all zero.
- R3: While exactly one of `rd` and `wr` is 1, `x_grp` has only bit `8*addr[6] + addr[5:3]` set. Otherwise `x_grp` is zero.
- R4: While `rd` and `wr` are both 1, `rw_conflict` is 1 and `x_rcol`, `x_wcol` and `x_grp` are all zero. Otherwise `rw_conflict` is 0.
- R5: `rd_win` goes to 1 after a clock edge that samples `pre_rd`=1. It goes to 0 after an edge that samples `rd`=0 when the previous edge sampled `rd`=1, unless that same edge also samples `pre_rd`=1, in which case the window stays open. At all other edges it holds its value. `rd` alone never opens the window.
- R6: While `rd_win`=1, `y_col` has only bit `addr[9:7]` set and `y_grp` has only bit `addr[12:10]` set. While `rd_win`=0 both are zero.
- R7: The module code is loaded from `addr[15:13]` at a clock edge that samples `adr_vld`=1 when the previous edge sampled `adr_vld`=0. At every other edge the code is held, including while `adr_vld` stays high.
- R8: For a module code of 0 to 4, `mod_sel` has only that bit set and `mod_oor`=0. For a code of 5 to 7, `mod_sel` is zero and `mod_oor`=1.
- R9: After reset, `rd_win`=0 and the module code is 0, so `mod_sel`=5'b00001 and `mod_oor`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Memory address |
| adr_vld | input | 1 | Address-valid strobe; its rising edge loads the module code |
| pre_rd | input | 1 | Pre-read strobe; opens the Y read window |
| rd | input | 1 | Main read strobe |
| wr | input | 1 | Write strobe |
| x_rcol | output | 8 | X read column selects |
| x_wcol | output | 8 | X write column selects |
| x_grp | output | 16 | X group selects |
| y_col | output | 8 | Y column selects |
| y_grp | output | 8 | Y group selects |
| rd_win | output | 1 | Y read window is open |
| rw_conflict | output | 1 | Read and write asserted together |
| mod_sel | output | 5 | One-hot stack-module select |
| mod_oor | output | 1 | Module code is out of range |

## Verification
The block holds only two pieces of state: the read-window flag with its copy of the previous read strobe, and the module code with its copy of the previous address-valid strobe. A wrong window state shows on `rd_win` and on every Y select one cycle after the edge that went wrong. A wrong module code shows on `mod_sel` and `mod_oor` in that same cycle and stays there until the next rising edge of `adr_vld`. The X path holds no state, so any decode or gating fault shows on the X outputs in the same cycle as the stimulus.

// File: rtl/core_drv_pkg.sv
package core_drv_pkg;
  localparam int unsigned XCOL_W   = 3;
  localparam int unsigned XHALF_W  = 3;
  localparam int unsigned YCOL_W   = 3;
  localparam int unsigned YGRP_W   = 3;
  localparam int unsigned MODC_W   = 3;
  localparam int unsigned MOD_NUM  = 5;

  localparam int unsigned XCOL_N   = 1 << XCOL_W;
  localparam int unsigned XHALF_N  = 1 << XHALF_W;
  localparam int unsigned XGRP_N   = 2 * XHALF_N;
  localparam int unsigned YCOL_N   = 1 << YCOL_W;
  localparam int unsigned YGRP_N   = 1 << YGRP_W;

  localparam int unsigned XCOL_LSB  = 0;
  localparam int unsigned XHALF_LSB = XCOL_LSB + XCOL_W;
  localparam int unsigned XSIDE_BIT = XHALF_LSB + XHALF_W;
  localparam int unsigned YCOL_LSB  = XSIDE_BIT + 1;
  localparam int unsigned YGRP_LSB  = YCOL_LSB + YCOL_W;
  localparam int unsigned MODC_LSB  = YGRP_LSB + YGRP_W;
  localparam int unsigned ADDR_W    = MODC_LSB + MODC_W;
endpackage

// File: rtl/core_onehot_dec.sv
module core_onehot_dec #(
  parameter int unsigned IW = 3,
  parameter int unsigned OW = 1 << IW
) (
  input  logic          en,
  input  logic [IW-1:0] idx,
  output logic [OW-1:0] sel
);
  for (genvar i = 0; i < OW; i++) begin : g_line
    assign sel[i] = en && (idx == IW'(i));
  end
endmodule

// File: rtl/core_x_drive.sv
module core_x_drive
  import core_drv_pkg::*;
(
  input  logic               rd,
  input  logic               wr,
  input  logic [XCOL_W-1:0]  col_idx,
  input  logic [XHALF_W-1:0] grp_idx,
  input  logic               side,
  output logic [XCOL_N-1:0]  rcol,
  output logic [XCOL_N-1:0]  wcol,
  output logic [XGRP_N-1:0]  grp,
  output logic               conflict
);
  logic rd_en;
  logic wr_en;
  logic [1:0] dir_en;
  logic [1:0][1:0][XHALF_N-1:0] part;

  always_comb begin
    conflict = rd && wr;
    rd_en    = rd && !wr;
    wr_en    = wr && !rd;
    dir_en   = {wr_en, rd_en};
  end

  core_onehot_dec #(.IW(XCOL_W)) u_rcol (.en(rd_en), .idx(col_idx), .sel(rcol));
  core_onehot_dec #(.IW(XCOL_W)) u_wcol (.en(wr_en), .idx(col_idx), .sel(wcol));

  for (genvar d = 0; d < 2; d++) begin : g_dir
    for (genvar h = 0; h < 2; h++) begin : g_half
      core_onehot_dec #(.IW(XHALF_W)) u_half (
        .en  (dir_en[d] && (side == 1'(h))),
        .idx (grp_idx),
        .sel (part[d][h])
      );
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_merge
    assign grp[h*XHALF_N +: XHALF_N] = part[0][h] | part[1][h];
  end
endmodule

// File: rtl/core_y_window.sv
module core_y_window
  import core_drv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pre_rd,
  input  logic              rd,
  input  logic [YCOL_W-1:0] col_idx,
  input  logic [YGRP_W-1:0] grp_idx,
  output logic              win,
  output logic [YCOL_N-1:0] col,
  output logic [YGRP_N-1:0] grp
);
  logic rd_q;
  logic win_q;
  logic win_d;
  logic rd_fall;

  always_comb begin
    rd_fall = rd_q && !rd;
    win_d   = win_q;
    if (pre_rd) begin
      win_d = 1'b1;
    end else if (rd_fall) begin
      win_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      win_q <= 1'b0;
    end else begin
      rd_q  <= rd;
      win_q <= win_d;
    end
  end

  assign win = win_q;

  core_onehot_dec #(.IW(YCOL_W)) u_ycol (.en(win_q), .idx(col_idx), .sel(col));
  core_onehot_dec #(.IW(YGRP_W)) u_ygrp (.en(win_q), .idx(grp_idx), .sel(grp));
endmodule

// File: rtl/core_mod_latch.sv
module core_mod_latch
  import core_drv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld,
  input  logic [MODC_W-1:0] code_in,
  output logic [MOD_NUM-1:0] sel,
  output logic              oor
);
  logic              vld_q;
  logic              load;
  logic [MODC_W-1:0] code_q;
  logic [MODC_W-1:0] code_d;

  always_comb begin
    load   = vld && !vld_q;
    code_d = load ? code_in : code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      code_q <= '0;
    end else begin
      vld_q  <= vld;
      code_q <= code_d;
    end
  end

  assign oor = (code_q >= MODC_W'(MOD_NUM));

  core_onehot_dec #(.IW(MODC_W), .OW(MOD_NUM)) u_mdec (
    .en  (1'b1),
    .idx (code_q),
    .sel (sel)
  );
endmodule

// File: rtl/core_addr_drive.sv
module core_addr_drive
  import core_drv_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               adr_vld,
  input  logic               pre_rd,
  input  logic               rd,
  input  logic               wr,
  output logic [XCOL_N-1:0]  x_rcol,
  output logic [XCOL_N-1:0]  x_wcol,
  output logic [XGRP_N-1:0]  x_grp,
  output logic [YCOL_N-1:0]  y_col,
  output logic [YGRP_N-1:0]  y_grp,
  output logic               rd_win,
  output logic               rw_conflict,
  output logic [MOD_NUM-1:0] mod_sel,
  output logic               mod_oor
);
  logic rst_s1;
  logic rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1  <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      rst_s1  <= 1'b1;
      rst_n_s <= rst_s1;
    end
  end

  core_x_drive u_x (
    .rd       (rd),
    .wr       (wr),
    .col_idx  (addr[XCOL_LSB +: XCOL_W]),
    .grp_idx  (addr[XHALF_LSB +: XHALF_W]),
    .side     (addr[XSIDE_BIT]),
    .rcol     (x_rcol),
    .wcol     (x_wcol),
    .grp      (x_grp),
    .conflict (rw_conflict)
  );

  core_y_window u_y (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .pre_rd  (pre_rd),
    .rd      (rd),
    .col_idx (addr[YCOL_LSB +: YCOL_W]),
    .grp_idx (addr[YGRP_LSB +: YGRP_W]),
    .win     (rd_win),
    .col     (y_col),
    .grp     (y_grp)
  );

  core_mod_latch u_mod (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .vld     (adr_vld),
    .code_in (addr[MODC_LSB +: MODC_W]),
    .sel     (mod_sel),
    .oor     (mod_oor)
  );
endmodule

// File: rtl/core_addr_drive_chk.sv
module core_addr_drive_chk
  import core_drv_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               adr_vld,
  input logic               pre_rd,
  input logic               rd,
  input logic               wr,
  input logic [XCOL_N-1:0]  x_rcol,
  input logic [XCOL_N-1:0]  x_wcol,
  input logic [XGRP_N-1:0]  x_grp,
  input logic [YCOL_N-1:0]  y_col,
  input logic [YGRP_N-1:0]  y_grp,
  input logic               rd_win,
  input logic               rw_conflict,
  input logic [MOD_NUM-1:0] mod_sel,
  input logic               mod_oor
);
  a_r1_rcol_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> (x_rcol == '0));
  a_r1_rcol_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(x_rcol));
  a_r2_wcol_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |-> (x_wcol == '0));
  a_r3_grp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(x_grp));
  a_r3_grp_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (x_grp != '0) |-> (rd ^ wr));
  a_r4_conflict_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && wr) |-> (rw_conflict && x_rcol == '0 && x_wcol == '0 && x_grp == '0));
  a_r5_window_opens: assert property (@(posedge clk) disable iff (!rst_n)
    pre_rd |=> rd_win);
  a_r5_window_closes: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd) && !rd && !pre_rd) |=> !rd_win);
  a_r6_y_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_win |-> (y_col == '0 && y_grp == '0));
  a_r6_y_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    rd_win |-> ($countones(y_col) == 1 && $countones(y_grp) == 1));
  a_r7_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adr_vld |=> ($stable(mod_sel) && $stable(mod_oor)));
  a_r8_oor_blank: assert property (@(posedge clk) disable iff (!rst_n)
    mod_oor |-> (mod_sel == '0));
  a_r8_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_oor |-> $onehot(mod_sel));
endmodule

bind core_addr_drive core_addr_drive_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .adr_vld     (adr_vld),
  .pre_rd      (pre_rd),
  .rd          (rd),
  .wr          (wr),
  .x_rcol      (x_rcol),
  .x_wcol      (x_wcol),
  .x_grp       (x_grp),
  .y_col       (y_col),
  .y_grp       (y_grp),
  .rd_win      (rd_win),
  .rw_conflict (rw_conflict),
  .mod_sel     (mod_sel),
  .mod_oor     (mod_oor)
);

// File: tb/core_addr_drive_bench.sv
module core_addr_drive_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {rd, wr, expected group index (31 = none), addr}
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 1'b0, 5'd0,  16'h0000},
    {1'b0, 1'b1, 5'd15, 16'h007D},
    {1'b1, 1'b0, 5'd8,  16'h0040},
    {1'b0, 1'b1, 5'd7,  16'h003B},
    {1'b1, 1'b0, 5'd2,  16'h0015},
    {1'b1, 1'b1, 5'd31, 16'h1FFF},
    {1'b0, 1'b0, 5'd31, 16'h002A},
    {1'b0, 1'b1, 5'd12, 16'h0066}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic adr_vld = 1'b0, pre_rd = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0] x_rcol, x_wcol, y_col, y_grp;
  logic [15:0] x_grp;
  logic rd_win, rw_conflict, mod_oor;
  logic [4:0] mod_sel;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_addr_drive u_core_addr_drive (
    .clk(clk), .rst_n(rst_n), .addr(addr), .adr_vld(adr_vld), .pre_rd(pre_rd),
    .rd(rd), .wr(wr), .x_rcol(x_rcol), .x_wcol(x_wcol), .x_grp(x_grp),
    .y_col(y_col), .y_grp(y_grp), .rd_win(rd_win), .rw_conflict(rw_conflict),
    .mod_sel(mod_sel), .mod_oor(mod_oor)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) tick();
    // R9 reset state
    check("R9 rd_win", 32'(rd_win), 32'd0);
    check("R9 mod_sel", 32'(mod_sel), 32'h01);
    check("R9 mod_oor", 32'(mod_oor), 32'd0);
    check("R4 idle conflict", 32'(rw_conflict), 32'd0);

    // Table of X decode vectors: R1 R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      logic v_rd, v_wr;
      logic [4:0] g;
      logic [15:0] a;
      logic [15:0] eg;
      logic [7:0] ec;
      @(negedge clk);
      {v_rd, v_wr, g, a} = VEC[i];
      addr = a; rd = v_rd; wr = v_wr;
      #2;
      ec = 8'(1) << a[2:0];
      eg = (g == 5'd31) ? 16'h0 : (16'(1) << g);
      check("R1 x_rcol", 32'(x_rcol), (v_rd && !v_wr) ? 32'(ec) : 32'd0);
      check("R2 x_wcol", 32'(x_wcol), (v_wr && !v_rd) ? 32'(ec) : 32'd0);
      check("R3 x_grp", 32'(x_grp), 32'(eg));
      check("R4 conflict", 32'(rw_conflict), 32'(v_rd && v_wr));
    end

    // R5 / R6 window
    @(negedge clk); rd = 0; wr = 0; addr = 16'h0A80;
    tick();
    check("R6 y idle", 32'(y_col), 32'd0);
    @(negedge clk); rd = 1;
    tick();
    check("R5 rd alone", 32'(rd_win), 32'd0);
    @(negedge clk); rd = 0;
    tick();
    @(negedge clk); pre_rd = 1;
    tick();
    check("R5 open", 32'(rd_win), 32'd1);
    check("R6 y_col", 32'(y_col), 32'h20);
    check("R6 y_grp", 32'(y_grp), 32'h04);
    @(negedge clk); pre_rd = 0; rd = 1;
    tick(); tick();
    check("R5 held", 32'(rd_win), 32'd1);
    @(negedge clk); rd = 0;
    tick();
    check("R5 closed", 32'(rd_win), 32'd0);
    check("R6 y closed", 32'(y_grp), 32'd0);
    // set wins over close
    @(negedge clk); pre_rd = 1; rd = 1;
    tick();
    @(negedge clk); rd = 0;
    tick();
    check("R5 set wins", 32'(rd_win), 32'd1);
    @(negedge clk); pre_rd = 0;
    tick();
    check("R5 no fall hold", 32'(rd_win), 32'd1);
    @(negedge clk); rd = 1;
    tick();
    @(negedge clk); rd = 0;
    tick();
    check("R5 closed again", 32'(rd_win), 32'd0);

    // R7 / R8 module code
    @(negedge clk); addr = 16'h6000; adr_vld = 1;
    tick();
    check("R7 load code 3", 32'(mod_sel), 32'h08);
    @(negedge clk); addr = 16'hE000;
    tick();
    check("R7 held while high", 32'(mod_sel), 32'h08);
    @(negedge clk); adr_vld = 0;
    tick();
    check("R7 held while low", 32'(mod_sel), 32'h08);
    @(negedge clk); adr_vld = 1;
    tick();
    check("R8 oor sel", 32'(mod_sel), 32'd0);
    check("R8 oor flag", 32'(mod_oor), 32'd1);
    @(negedge clk); adr_vld = 0; addr = 16'h8000;
    tick();
    @(negedge clk); adr_vld = 1;
    tick();
    check("R8 code 4", 32'(mod_sel), 32'h10);
    check("R8 in range", 32'(mod_oor), 32'd0);

    finish_run();
  end
endmodule